// File: doc/BRIEF.md
# PCM Voice Serial Port

This block is a full-duplex serial port for a mono voice codec. Each frame carries one 16-bit two's-complement sample in each direction, most significant bit first. Four lines carry the traffic: a bit clock, a frame sync, a serial output with its own output enable, and a serial input. The port can act as master, deriving bit clock and frame sync from the system clock through a programmable divider. It can also act as slave, following a bit clock and frame sync that arrive from outside and are synchronous to the system clock.

A 2-bit mode field selects a one-bit-wide frame sync (the data word follows in the next 16 bit clocks) or a sixteen-bit-wide frame sync (the data word lies under the sync). The other two field values disable the port. The bit clock and the frame sync each have their own polarity control. The parallel side has a transmit word register with a load strobe and a receive word register with a one-cycle valid strobe.

Top module: `pcm_voice_port`

## Requirements
- R1: The transmit word goes out on `sd_out` most significant bit first, one bit per bit clock, and the word captured by a peer equals the word loaded.
- R2: Mode 2'b01 (short sync): frame sync is active for exactly one bit clock, and data bits 15..0 occupy the 16 bit clocks that follow it.
- R3: Mode 2'b10 (long sync): frame sync is active for 16 bit clocks, and data bits 15..0 occupy those same 16 bit clocks.
- R4: `sd_oe` is 1 only during the 16 data bit clocks of a frame and 0 in every other bit clock.
- R5: Receive bits are sampled inside the data slot only and assembled MSB first into `rx_word`. `rx_valid` pulses for exactly one system clock once per frame, after bit 0. Input levels outside the slot have no effect on `rx_word`.
- R6: In master mode each bit clock half period lasts `cfg_half_div`+1 system clocks, and a frame is 32 bit clocks long.
- R7: In slave mode the port frames its data on the external `bclk_in` and `fs_in`.
- R8: With the inversion controls removed (logical level = pin XOR control), output data changes after a logical falling bit clock edge and input data is sampled on a logical rising edge. Bit clock and frame sync polarities are controlled independently.
- R9: With `cfg_clk_en`=1 and `cfg_data_en`=0, a master still produces bit clock and frame sync, but `sd_oe` stays 0 and `rx_valid` never pulses.
- R10: A word loaded with `tx_load` during a frame does not change the word in flight. It is sent in the next frame.
- R11: Mode values 2'b00 and 2'b11 produce no active frame sync, no `sd_oe` and no `rx_valid`.
- R12: While `rst` is high, `sd_oe`, `rx_valid`, `rx_word`, and in master mode with the clock disabled `bclk_out` and `fs_out`, are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_master | input | 1 | 1: generate bit clock and frame sync; 0: follow external ones |
| cfg_fs_mode | input | 2 | 01 short sync, 10 long sync, 00/11 disabled |
| cfg_fs_inv | input | 1 | Invert frame sync at the pins |
| cfg_bclk_inv | input | 1 | Invert bit clock at the pins |
| cfg_clk_en | input | 1 | Enable master clock generation |
| cfg_data_en | input | 1 | Enable transmit and receive data path |
| cfg_half_div | input | DIV_W | Bit clock half period minus one, in system clocks |
| bclk_in | input | 1 | Bit clock from an external master |
| fs_in | input | 1 | Frame sync from an external master |
| bclk_out | output | 1 | Generated bit clock (0 in slave mode) |
| fs_out | output | 1 | Generated frame sync (0 in slave mode) |
| tx_word | input | 16 | Sample to transmit |
| tx_load | input | 1 | Strobe that captures `tx_word` |
| rx_word | output | 16 | Last received sample |
| rx_valid | output | 1 | One-clock strobe when `rx_word` updates |
| sd_in | input | 1 | Serial receive data |
| sd_out | output | 1 | Serial transmit data |
| sd_oe | output | 1 | Output enable for `sd_out`; 0 means the line floats |

## Verification
The bench acts as the codec's peer at the pins. It checks the data slot's position against the sync in both sync widths, so a design that shifted data by one bit clock would return a rotated word. Noise driven on `sd_in` outside the slot, with an all-zero sample inside it, exposes a receiver that samples past bit 0. A word loaded mid-frame would show up in the current frame if the load were not deferred. Inverted polarity runs and the reserved and clock-only runs catch a port that drives the line or strobes data when it must stay quiet.

// File: rtl/pcm_vp_pkg.sv
package pcm_vp_pkg;

    localparam int WORD_W = 16;
    localparam int BIT_W  = $clog2(WORD_W);

    typedef enum logic [1:0] {
        FS_NONE0 = 2'b00,
        FS_SHORT = 2'b01,
        FS_LONG  = 2'b10,
        FS_NONE3 = 2'b11
    } fs_mode_e;

    // Line events seen in the logical (polarity-removed) domain
    typedef struct packed {
        logic rise;
        logic fall;
        logic fs;
    } line_ev_t;

    function automatic logic mode_ok(fs_mode_e m);
        return (m == FS_SHORT) || (m == FS_LONG);
    endfunction

    function automatic int first_slot(fs_mode_e m);
        return (m == FS_SHORT) ? 1 : 0;
    endfunction

    function automatic logic in_data(fs_mode_e m, int s);
        return mode_ok(m) && (s >= first_slot(m)) && (s < first_slot(m) + WORD_W);
    endfunction

    // Bit of the word carried in slot s (MSB first)
    function automatic int bit_pos(fs_mode_e m, int s);
        return WORD_W - 1 - (s - first_slot(m));
    endfunction

endpackage

// File: rtl/pcm_vp_clkgen.sv
module pcm_vp_clkgen
    import pcm_vp_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int FRAME_BITS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  fs_mode_e         mode,
    input  logic [DIV_W-1:0] half_div,
    output logic             bk,
    output logic             fs
);
    localparam int GS_W = $clog2(FRAME_BITS);

    logic [DIV_W-1:0] dcnt;
    logic [GS_W-1:0]  gslot;
    logic [GS_W-1:0]  gnext;
    logic             fs_next;

    always_comb begin
        gnext = (gslot == GS_W'(FRAME_BITS - 1)) ? '0 : gslot + GS_W'(1);
        unique case (mode)
            FS_SHORT: fs_next = (gnext == '0);
            FS_LONG:  fs_next = (int'(gnext) < WORD_W);
            default:  fs_next = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            dcnt  <= '0;
            bk    <= 1'b0;
            fs    <= 1'b0;
            gslot <= GS_W'(FRAME_BITS - 1);
        end else if (dcnt == half_div) begin
            dcnt <= '0;
            bk   <= ~bk;
            if (bk) begin
                gslot <= gnext;
                fs    <= fs_next;
            end
        end else begin
            dcnt <= dcnt + DIV_W'(1);
        end
    end

    // Frame sync only moves together with a falling bit clock
    assert_fs_on_fall_R6: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && (fs != $past(fs))) |-> ($past(bk) && !bk));

endmodule

// File: rtl/pcm_vp_pinsync.sv
module pcm_vp_pinsync
    import pcm_vp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     master,
    input  logic     gen_bk,
    input  logic     gen_fs,
    input  logic     bclk_in,
    input  logic     fs_in,
    input  logic     bclk_inv,
    input  logic     fs_inv,
    output line_ev_t ev
);
    logic bk_s, bk_q, fs_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            bk_s <= 1'b0;
            bk_q <= 1'b0;
            fs_s <= 1'b0;
        end else begin
            bk_s <= master ? gen_bk : (bclk_in ^ bclk_inv);
            fs_s <= master ? gen_fs : (fs_in ^ fs_inv);
            bk_q <= bk_s;
        end
    end

    always_comb begin
        ev.rise = bk_s & ~bk_q;
        ev.fall = ~bk_s & bk_q;
        ev.fs   = fs_s;
    end

endmodule

// File: rtl/pcm_vp_frame.sv
module pcm_vp_frame
    import pcm_vp_pkg::*;
#(
    parameter int SLOT_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  fs_mode_e          mode,
    input  line_ev_t          ev,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              tx_load,
    input  logic              sd_in,
    output logic              sd_out,
    output logic              sd_oe,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid
);
    localparam logic [SLOT_W-1:0] SLOT_IDLE = '1;

    logic [SLOT_W-1:0] slot, nslot;
    logic              fs_prev, start;
    logic [WORD_W-1:0] tx_hold, tx_cur, word_now, rx_sh;

    always_comb begin
        start    = ev.fall && ev.fs && !fs_prev && mode_ok(mode);
        nslot    = start ? '0 : ((slot == SLOT_IDLE) ? SLOT_IDLE : slot + SLOT_W'(1));
        word_now = start ? tx_hold : tx_cur;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot     <= SLOT_IDLE;
            fs_prev  <= 1'b0;
            tx_hold  <= '0;
            tx_cur   <= '0;
            rx_sh    <= '0;
            rx_word  <= '0;
            rx_valid <= 1'b0;
            sd_out   <= 1'b0;
            sd_oe    <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (tx_load) tx_hold <= tx_word;
            if (!en) begin
                slot    <= SLOT_IDLE;
                fs_prev <= 1'b0;
                sd_out  <= 1'b0;
                sd_oe   <= 1'b0;
            end else begin
                if (ev.fall) begin
                    fs_prev <= ev.fs;
                    slot    <= nslot;
                    if (start) tx_cur <= tx_hold;
                    if (in_data(mode, int'(nslot))) begin
                        sd_oe  <= 1'b1;
                        sd_out <= word_now[BIT_W'(bit_pos(mode, int'(nslot)))];
                    end else begin
                        sd_oe  <= 1'b0;
                        sd_out <= 1'b0;
                    end
                end
                if (ev.rise && in_data(mode, int'(slot))) begin
                    rx_sh <= {rx_sh[WORD_W-2:0], sd_in};
                    if (bit_pos(mode, int'(slot)) == 0) begin
                        rx_word  <= {rx_sh[WORD_W-2:0], sd_in};
                        rx_valid <= 1'b1;
                    end
                end
            end
        end
    end

    assert_oe_gated_R11: assert property (@(posedge clk) disable iff (rst)
        sd_oe |-> ($past(en) && mode_ok(fs_mode_e'($past(mode)))));

    assert_valid_single_R5: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    assert_valid_after_rise_R5: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(ev.rise));

    assert_drive_on_fall_R8: assert property (@(posedge clk) disable iff (rst)
        (en && !ev.fall) |=> ($stable(sd_out) && $stable(sd_oe)));

endmodule

// File: rtl/pcm_voice_port.sv
module pcm_voice_port
    import pcm_vp_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int FRAME_BITS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_master,
    input  logic [1:0]        cfg_fs_mode,
    input  logic              cfg_fs_inv,
    input  logic              cfg_bclk_inv,
    input  logic              cfg_clk_en,
    input  logic              cfg_data_en,
    input  logic [DIV_W-1:0]  cfg_half_div,
    input  logic              bclk_in,
    input  logic              fs_in,
    output logic              bclk_out,
    output logic              fs_out,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              tx_load,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid,
    input  logic              sd_in,
    output logic              sd_out,
    output logic              sd_oe
);
    localparam int SLOT_W = $clog2(FRAME_BITS) + 1;

    fs_mode_e mode;
    logic     gen_bk, gen_fs;
    line_ev_t ev;

    assign mode = fs_mode_e'(cfg_fs_mode);

    pcm_vp_clkgen #(.DIV_W(DIV_W), .FRAME_BITS(FRAME_BITS)) u_clkgen (
        .clk      (clk),
        .rst      (rst),
        .en       (cfg_master & cfg_clk_en),
        .mode     (mode),
        .half_div (cfg_half_div),
        .bk       (gen_bk),
        .fs       (gen_fs)
    );

    pcm_vp_pinsync u_pins (
        .clk      (clk),
        .rst      (rst),
        .master   (cfg_master),
        .gen_bk   (gen_bk),
        .gen_fs   (gen_fs),
        .bclk_in  (bclk_in),
        .fs_in    (fs_in),
        .bclk_inv (cfg_bclk_inv),
        .fs_inv   (cfg_fs_inv),
        .ev       (ev)
    );

    pcm_vp_frame #(.SLOT_W(SLOT_W)) u_frame (
        .clk      (clk),
        .rst      (rst),
        .en       (cfg_data_en),
        .mode     (mode),
        .ev       (ev),
        .tx_word  (tx_word),
        .tx_load  (tx_load),
        .sd_in    (sd_in),
        .sd_out   (sd_out),
        .sd_oe    (sd_oe),
        .rx_word  (rx_word),
        .rx_valid (rx_valid)
    );

    assign bclk_out = cfg_master ? (gen_bk ^ cfg_bclk_inv) : 1'b0;
    assign fs_out   = cfg_master ? (gen_fs ^ cfg_fs_inv)   : 1'b0;

endmodule

// File: tb/pcm_voice_port_tb.sv
`timescale 1ns/1ps
module pcm_voice_port_tb;

    localparam int HALF_SLAVE = 4;

    typedef struct packed {
        logic        master;
        logic [1:0]  mode;
        logic        fsinv;
        logic        bkinv;
        logic [7:0]  div;
        logic [15:0] tx;
        logic [15:0] rx;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b1, 2'b01, 1'b0, 1'b0, 8'd2, 16'hA5C3, 16'h3C5A},
        '{1'b1, 2'b10, 1'b0, 1'b0, 8'd3, 16'h8001, 16'h7FFE},
        '{1'b1, 2'b01, 1'b1, 1'b1, 8'd2, 16'h1234, 16'hFEDC},
        '{1'b0, 2'b10, 1'b0, 1'b0, 8'd0, 16'hFFFF, 16'h0000},
        '{1'b0, 2'b01, 1'b1, 1'b0, 8'd0, 16'h0F0F, 16'h8000},
        '{1'b0, 2'b10, 1'b0, 1'b1, 8'd0, 16'h6B2D, 16'h94D2}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_master = 1'b1;
    logic [1:0]  cfg_fs_mode = 2'b01;
    logic        cfg_fs_inv = 1'b0;
    logic        cfg_bclk_inv = 1'b0;
    logic        cfg_clk_en = 1'b0;
    logic        cfg_data_en = 1'b0;
    logic [7:0]  cfg_half_div = 8'd2;
    logic        bclk_in, fs_in;
    logic        bclk_out, fs_out;
    logic [15:0] tx_word = '0;
    logic        tx_load = 1'b0;
    logic [15:0] rx_word;
    logic        rx_valid;
    logic        sd_in;
    logic        sd_out, sd_oe;

    pcm_voice_port u_dut (
        .clk(clk), .rst(rst), .cfg_master(cfg_master), .cfg_fs_mode(cfg_fs_mode),
        .cfg_fs_inv(cfg_fs_inv), .cfg_bclk_inv(cfg_bclk_inv), .cfg_clk_en(cfg_clk_en),
        .cfg_data_en(cfg_data_en), .cfg_half_div(cfg_half_div), .bclk_in(bclk_in),
        .fs_in(fs_in), .bclk_out(bclk_out), .fs_out(fs_out), .tx_word(tx_word),
        .tx_load(tx_load), .rx_word(rx_word), .rx_valid(rx_valid), .sd_in(sd_in),
        .sd_out(sd_out), .sd_oe(sd_oe)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // peer control, written only by the initial block
    logic        peer_clr = 1'b1;
    logic        slave_run = 1'b0;
    logic [15:0] peer_rx = '0;

    // peer state, written only by the peer process
    int          pslot, nf, nstart, nfall, oe_err, oe_high, nvalid, vrun, vrun_max;
    int          last_rise, period, falls_in_frame, frame_len;
    logic        pb_prev, pf_prev, sbk, sfs;
    int          hcnt, sslot;
    logic [15:0] cap, last_rx;
    logic [15:0] frames [0:7];

    function automatic logic tb_in_data(logic [1:0] m, int s);
        int f = (m == 2'b01) ? 1 : 0;
        return (m == 2'b01 || m == 2'b10) && s >= f && s < f + 16;
    endfunction

    function automatic int tb_idx(logic [1:0] m, int s);
        return s - ((m == 2'b01) ? 1 : 0);
    endfunction

    always @(negedge clk) begin
        logic pb, pf;
        cyc++;
        if (peer_clr) begin
            pslot = 1000; nf = 0; nstart = 0; nfall = 0; oe_err = 0; oe_high = 0;
            nvalid = 0; vrun = 0; vrun_max = 0; last_rise = -1; period = 0;
            falls_in_frame = 0; frame_len = 0; pb_prev = 1'b0; pf_prev = 1'b0;
            sbk = 1'b0; sfs = 1'b0; hcnt = 0; sslot = 31; cap = '0; last_rx = '0;
            sd_in = 1'b1;
        end else begin
            if (slave_run) begin
                if (hcnt == HALF_SLAVE - 1) begin
                    hcnt = 0;
                    sbk = ~sbk;
                    if (!sbk) begin
                        sslot = (sslot + 1) % 32;
                        sfs = (cfg_fs_mode == 2'b01) ? (sslot == 0) :
                              (cfg_fs_mode == 2'b10) ? (sslot < 16) : 1'b0;
                    end
                end else begin
                    hcnt++;
                end
            end
            pb = cfg_master ? (bclk_out ^ cfg_bclk_inv) : sbk;
            pf = cfg_master ? (fs_out ^ cfg_fs_inv) : sfs;
            if (pb_prev && !pb) begin
                nfall++;
                falls_in_frame++;
                if (pf && !pf_prev) begin
                    if (nstart > 0) frame_len = falls_in_frame;
                    falls_in_frame = 0;
                    nstart++;
                    pslot = 0;
                end else if (pslot < 1000) begin
                    pslot++;
                end
                pf_prev = pf;
                sd_in = tb_in_data(cfg_fs_mode, pslot) ? peer_rx[15 - tb_idx(cfg_fs_mode, pslot)] : 1'b1;
            end
            if (!pb_prev && pb) begin
                if (last_rise >= 0) period = cyc - last_rise;
                last_rise = cyc;
                if (tb_in_data(cfg_fs_mode, pslot)) begin
                    if (!sd_oe) oe_err++;
                    cap = {cap[14:0], sd_out};
                    if (tb_idx(cfg_fs_mode, pslot) == 15 && nf < 8) begin
                        frames[nf] = cap;
                        nf++;
                    end
                end else if (sd_oe) begin
                    oe_err++;
                end
            end
            pb_prev = pb;
            if (sd_oe) oe_high++;
            if (rx_valid) begin
                nvalid++; last_rx = rx_word; vrun++;
                if (vrun > vrun_max) vrun_max = vrun;
            end else begin
                vrun = 0;
            end
        end
        bclk_in = sbk ^ cfg_bclk_inv;
        fs_in   = sfs ^ cfg_fs_inv;
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic setup(logic m, logic [1:0] mode, logic fi, logic bi, logic [7:0] dv, logic [15:0] rxw);
        @(negedge clk);
        rst = 1'b1; peer_clr = 1'b1; slave_run = 1'b0;
        cfg_master = m; cfg_fs_mode = mode; cfg_fs_inv = fi; cfg_bclk_inv = bi;
        cfg_half_div = dv; cfg_clk_en = 1'b0; cfg_data_en = 1'b0; peer_rx = rxw;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic load(logic [15:0] w);
        tx_word = w; tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
    endtask

    task automatic go(logic clk_on, logic data_on);
        peer_clr = 1'b0;
        cfg_clk_en = clk_on; cfg_data_en = data_on; slave_run = !cfg_master;
    endtask

    task automatic wait_frames(int n);
        for (int i = 0; i < 6000 && !(nf >= n && nvalid >= n); i++) @(negedge clk);
    endtask

    initial begin
        sd_in = 1'b1;
        // R12: reset state
        repeat (3) @(negedge clk);
        chk("R12", {31'd0, sd_oe}, 32'd0, "sd_oe in reset");
        chk("R12", {31'd0, rx_valid}, 32'd0, "rx_valid in reset");
        chk("R12", {16'd0, rx_word}, 32'd0, "rx_word in reset");
        chk("R12", {30'd0, bclk_out, fs_out}, 32'd0, "bclk/fs in reset");

        // table of frame exchanges: R1 R2 R3 R4 R5 R6 R7 R8
        for (int v = 0; v < 6; v++) begin
            setup(VECS[v].master, VECS[v].mode, VECS[v].fsinv, VECS[v].bkinv, VECS[v].div, VECS[v].rx);
            load(VECS[v].tx);
            go(1'b1, 1'b1);
            wait_frames(2);
            chk(VECS[v].mode == 2'b01 ? "R1 R2" : "R1 R3", {16'd0, frames[0]}, {16'd0, VECS[v].tx}, "tx frame 0");
            chk("R1", {16'd0, frames[1]}, {16'd0, VECS[v].tx}, "tx frame 1");
            chk("R5", {16'd0, last_rx}, {16'd0, VECS[v].rx}, "rx word");
            chk("R5", vrun_max, 32'd1, "rx_valid width");
            chk("R4", oe_err, 32'd0, "oe outside slot or missing in slot");
            if (VECS[v].master) begin
                chk("R6", period, 2 * (VECS[v].div + 1), "bit clock period");
                chk("R6", frame_len, 32'd32, "bit clocks per frame");
            end else begin
                chk("R7", {31'd0, nstart >= 2}, 32'd1, "slave frames followed");
            end
            if (VECS[v].fsinv || VECS[v].bkinv)
                chk("R8", {16'd0, frames[0]}, {16'd0, VECS[v].tx}, "inverted polarity word");
        end

        // R10: word loaded mid-frame waits for next frame
        setup(1'b1, 2'b10, 1'b0, 1'b0, 8'd2, 16'h5555);
        load(16'hC0DE);
        go(1'b1, 1'b1);
        for (int i = 0; i < 3000 && !(nstart >= 1 && pslot == 5); i++) @(negedge clk);
        load(16'hBEEF);
        wait_frames(2);
        chk("R10", {16'd0, frames[0]}, 32'h0000C0DE, "word in flight kept");
        chk("R10", {16'd0, frames[1]}, 32'h0000BEEF, "new word next frame");

        // R11: reserved modes
        for (int m = 0; m < 2; m++) begin
            setup(1'b1, m == 0 ? 2'b00 : 2'b11, 1'b0, 1'b0, 8'd2, 16'h0000);
            load(16'hFFFF);
            go(1'b1, 1'b1);
            repeat (600) @(negedge clk);
            chk("R11", {31'd0, nfall > 0}, 32'd1, "bit clock runs");
            chk("R11", nstart, 32'd0, "no frame sync");
            chk("R11", oe_high, 32'd0, "no drive");
            chk("R11", nvalid, 32'd0, "no rx_valid");
        end

        // R9: clocks without data path
        setup(1'b1, 2'b10, 1'b0, 1'b0, 8'd2, 16'h1111);
        load(16'hFFFF);
        go(1'b1, 1'b0);
        repeat (600) @(negedge clk);
        chk("R9", {31'd0, nstart > 0}, 32'd1, "frame sync generated");
        chk("R9", oe_high, 32'd0, "no drive with data off");
        chk("R9", nvalid, 32'd0, "no rx_valid with data off");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=hang expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule